// File: doc/BRIEF.md
# Reset Cause and Control Unit

This block sits beside the reset distribution of a chip and keeps a sticky log of what caused the most recent resets. Its inputs are reset requests from several sources: the external pin, power-on, brown-out, watchdog, debugger and the core's system reset request. It is also told when the supply is below the brown-out-high level. Software reaches it through a simple register bus with an address, a write enable, write data and combinational read data.

Software can start a full power-on-class reset or a partial reset by writing an exact 8-bit key. It can hold a trace port in a static reset, and it can handle a brown-out-high interrupt through separate enable, status, set and clear registers. Each software reset produces a fixed-length pulse on its own output. A single write clears the whole cause log.

The asynchronous active-low reset is released through a two-stage synchronizer. Analog detection and the reset network itself are outside this block.

Top module: `rstctl_top`

## Requirements
- R1: After reset, every register reads 0 and the outputs `full_rst_o`, `part_rst_o`, `trace_rst_o` and `irq_o` are low.
- R2: A write of 0xD4 in `bus_wdata[7:0]` to offset 0x008 raises `full_rst_o` for exactly 4 cycles, starting on the cycle after the write. It also sets cause bit 3. A write of any other value to that offset does nothing.
- R3: A write of 0x1B in `bus_wdata[7:0]` to offset 0x004 raises `part_rst_o` for exactly 4 cycles, starting on the cycle after the write. It also sets cause bit 4. A write of any other value to that offset does nothing.
- R4: The cause log at offset 0x00C has these bits: 0 external, 1 power-on, 2 brown-out, 3 software full reset or core system request, 4 software partial reset, 5 debugger, 6 watchdog. A flag is set one cycle after its request and stays set as other flags are added.
- R5: A power-on request clears every other flag and leaves only bit 1 set. This takes priority over a clear write in the same cycle.
- R6: Writing 1 to bit 0 of offset 0x010 empties the cause log in one cycle. Requests that arrive in the same cycle are still logged. Writing 0 there does nothing.
- R7: Bit 0 of offset 0x014 drives `trace_rst_o`. Writing 1 sets it and writing 0 releases it. It changes only when that offset is written.
- R8: The configuration register at offset 0x000 has a brown-out reset enable in bit 0 and a watchdog enable field in bits 2:1. A brown-out request is logged only when bit 0 is 1. A watchdog request is logged only when the field is nonzero.
- R9: The interrupt registers use bit 0 of four offsets: enable at 0x200, status at 0x204, clear at 0x208 and set at 0x20C. Writing 1 to set, or `bod_high_i` being high, sets the status bit. Writing 1 to clear clears it, but a set in the same cycle wins. Writing 0 to set or clear does nothing. `irq_o` is status AND enable.
- R10: A software key write that arrives while its pulse is running is merged into that pulse. The pulse is not extended and still lasts 4 cycles in total.
- R11: The key offsets, the clear offsets and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_ext_i | input | 1 | External pin reset request |
| req_por_i | input | 1 | Power-on reset request |
| req_bod_i | input | 1 | Brown-out reset request |
| req_wdt_i | input | 1 | Watchdog reset request |
| req_dbg_i | input | 1 | Debugger reset request |
| req_sys_i | input | 1 | Core system reset request |
| bod_high_i | input | 1 | Supply is below the brown-out-high level |
| full_rst_o | output | 1 | Software full reset pulse |
| part_rst_o | output | 1 | Software partial reset pulse |
| trace_rst_o | output | 1 | Static trace-port reset |
| irq_o | output | 1 | Brown-out-high interrupt |

## Verification
The assertions assume that every request input and `bod_high_i` is synchronous to `clk` and is sampled as a level once per cycle. They also assume at most one register access per cycle, with the address stable while the write strobe is high. The stimulus changes every input one time unit after a falling edge, so all inputs are settled at each rising edge. It keeps all inputs idle for several cycles after reset is released, until the synchronizer has let the block out of reset. Requests last one cycle, except where a test needs a request to collide with a clear write or with an interrupt clear.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned NCAUSE = 7;

  // cause log bit positions
  localparam int unsigned C_EXT  = 0;
  localparam int unsigned C_POR  = 1;
  localparam int unsigned C_BOD  = 2;
  localparam int unsigned C_FULL = 3;
  localparam int unsigned C_PART = 4;
  localparam int unsigned C_DBG  = 5;
  localparam int unsigned C_WDT  = 6;

  // register offsets
  localparam int OFS_CFG   = 'h000;
  localparam int OFS_KPART = 'h004;
  localparam int OFS_KFULL = 'h008;
  localparam int OFS_CAUSE = 'h00C;
  localparam int OFS_CCLR  = 'h010;
  localparam int OFS_TRACE = 'h014;
  localparam int OFS_IEN   = 'h200;
  localparam int OFS_IST   = 'h204;
  localparam int OFS_ICLR  = 'h208;
  localparam int OFS_ISET  = 'h20C;

  localparam logic [7:0] KEY_FULL = 8'hD4;
  localparam logic [7:0] KEY_PART = 8'h1B;
endpackage

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              bod_high,
  input  logic [NCAUSE-1:0] cause,
  output logic              bod_en,
  output logic              wdt_en,
  output logic              fire_full,
  output logic              fire_part,
  output logic              cause_clr,
  output logic              trace_rst,
  output logic              irq
);
  logic [2:0] cfg_q, cfg_d;
  logic       trace_q, trace_d;
  logic       ien_q, ien_d;
  logic       ist_q, ist_d;
  logic       wr_cfg, wr_trace, wr_ien, ist_set, ist_clr;
  int         a;

  always_comb begin
    a         = int'(addr);
    wr_cfg    = we && (a == OFS_CFG);
    wr_trace  = we && (a == OFS_TRACE);
    wr_ien    = we && (a == OFS_IEN);
    ist_set   = bod_high || (we && (a == OFS_ISET) && wdata[0]);
    ist_clr   = we && (a == OFS_ICLR) && wdata[0];
    fire_full = we && (a == OFS_KFULL) && (wdata[7:0] == KEY_FULL);
    fire_part = we && (a == OFS_KPART) && (wdata[7:0] == KEY_PART);
    cause_clr = we && (a == OFS_CCLR) && wdata[0];
  end

  always_comb begin
    cfg_d   = wr_cfg   ? wdata[2:0] : cfg_q;
    trace_d = wr_trace ? wdata[0]   : trace_q;
    ien_d   = wr_ien   ? wdata[0]   : ien_q;
    if (ist_set)      ist_d = 1'b1;
    else if (ist_clr) ist_d = 1'b0;
    else              ist_d = ist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      trace_q <= 1'b0;
      ien_q   <= 1'b0;
      ist_q   <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      trace_q <= trace_d;
      ien_q   <= ien_d;
      ist_q   <= ist_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (a)
      OFS_CFG:   rdata[2:0]        = cfg_q;
      OFS_CAUSE: rdata[NCAUSE-1:0] = cause;
      OFS_TRACE: rdata[0]          = trace_q;
      OFS_IEN:   rdata[0]          = ien_q;
      OFS_IST:   rdata[0]          = ist_q;
      default:   rdata             = '0;
    endcase
  end

  assign bod_en    = cfg_q[0];
  assign wdt_en    = |cfg_q[2:1];
  assign trace_rst = trace_q;
  assign irq       = ist_q & ien_q;

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == OFS_ISET && wdata[0]) |=> ist_q);
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) == OFS_ICLR && wdata[0] && !bod_high) |=> !ist_q);
  // R7
  trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && int'(addr) == OFS_TRACE) |=> $stable(trace_q));
endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause
  import rstctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] ev,
  input  logic              clr,
  output logic [NCAUSE-1:0] stat
);
  localparam logic [NCAUSE-1:0] POR_ONLY = NCAUSE'(1) << C_POR;

  logic [NCAUSE-1:0] stat_q, stat_d;

  always_comb begin
    if (ev[C_POR])  stat_d = POR_ONLY;
    else if (clr)   stat_d = ev;
    else            stat_d = stat_q | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  // R5
  por_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[C_POR] |=> (stat_q == POR_ONLY));
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev[C_POR] && !clr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev[C_POR]) |=> (stat_q == $past(ev)));
endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    if (busy)      cnt_d = cnt_q - 1'b1;
    else if (fire) cnt_d = CW'(LEN);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = busy;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LEN));
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> pulse);
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              req_ext_i,
  input  logic              req_por_i,
  input  logic              req_bod_i,
  input  logic              req_wdt_i,
  input  logic              req_dbg_i,
  input  logic              req_sys_i,
  input  logic              bod_high_i,
  output logic              full_rst_o,
  output logic              part_rst_o,
  output logic              trace_rst_o,
  output logic              irq_o
);
  localparam int NPULSE = 2;

  logic [1:0]        sync_q;
  logic              rst_n_int;
  logic [NCAUSE-1:0] ev, stat;
  logic              bod_en, wdt_en, fire_full, fire_part, cause_clr;
  logic [NPULSE-1:0] fires, pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_int = sync_q[1];

  always_comb begin
    ev         = '0;
    ev[C_EXT]  = req_ext_i;
    ev[C_POR]  = req_por_i;
    ev[C_BOD]  = req_bod_i & bod_en;
    ev[C_FULL] = fire_full | req_sys_i;
    ev[C_PART] = fire_part;
    ev[C_DBG]  = req_dbg_i;
    ev[C_WDT]  = req_wdt_i & wdt_en;
  end

  rstctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n_int), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .bod_high(bod_high_i),
    .cause(stat), .bod_en(bod_en), .wdt_en(wdt_en),
    .fire_full(fire_full), .fire_part(fire_part), .cause_clr(cause_clr),
    .trace_rst(trace_rst_o), .irq(irq_o)
  );

  rstctl_cause cause_i (
    .clk(clk), .rst_n(rst_n_int), .ev(ev), .clr(cause_clr), .stat(stat)
  );

  assign fires = {fire_part, fire_full};

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    rstctl_pulse #(.LEN(PULSE_LEN)) pulse_i (
      .clk(clk), .rst_n(rst_n_int), .fire(fires[g]), .pulse(pulses[g])
    );
  end

  assign full_rst_o = pulses[0];
  assign part_rst_o = pulses[1];
endmodule

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req_ext = 0, req_por = 0, req_bod = 0, req_wdt = 0;
  logic req_dbg = 0, req_sys = 0, bod_hi = 0;
  logic full_rst, part_rst, trace_rst, irq;

  int checks = 0;
  int errors = 0;
  bit chk_en = 0;
  int full_hi = 0;
  int part_hi = 0;

  always #5 clk = ~clk;

  rstctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .req_ext_i(req_ext), .req_por_i(req_por), .req_bod_i(req_bod),
    .req_wdt_i(req_wdt), .req_dbg_i(req_dbg), .req_sys_i(req_sys),
    .bod_high_i(bod_hi), .full_rst_o(full_rst), .part_rst_o(part_rst),
    .trace_rst_o(trace_rst), .irq_o(irq)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cfg, m_stat, m_trc, m_ien, m_ist, m_full, m_part;

  function automatic int m_read(input int a);
    case (a)
      'h000: return m_cfg;
      'h00C: return m_stat;
      'h014: return m_trc;
      'h200: return m_ien;
      'h204: return m_ist;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      'h000: return "R8";
      'h00C: return "R4";
      'h014: return "R7";
      'h200, 'h204: return "R9";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_stat = 0; m_trc = 0; m_ien = 0; m_ist = 0;
      m_full = 0; m_part = 0;
    end else begin
      int a; int ev; bit ff; bit fp; bit setv; bit clrv;
      a  = int'(addr);
      ff = we && a == 'h008 && wdata[7:0] == 8'hD4;
      fp = we && a == 'h004 && wdata[7:0] == 8'h1B;
      ev = 0;
      if (req_ext) ev |= 1;
      if (req_por) ev |= 2;
      if (req_bod && (m_cfg & 1) != 0) ev |= 4;
      if (ff || req_sys) ev |= 8;
      if (fp) ev |= 16;
      if (req_dbg) ev |= 32;
      if (req_wdt && (m_cfg & 6) != 0) ev |= 64;
      if ((ev & 2) != 0) m_stat = 2;
      else if (we && a == 'h010 && wdata[0]) m_stat = ev;
      else m_stat = m_stat | ev;
      if (we && a == 'h000) m_cfg = int'(wdata[2:0]);
      if (we && a == 'h014) m_trc = int'(wdata[0]);
      if (we && a == 'h200) m_ien = int'(wdata[0]);
      setv = bod_hi || (we && a == 'h20C && wdata[0]);
      clrv = we && a == 'h208 && wdata[0];
      if (setv) m_ist = 1;
      else if (clrv) m_ist = 0;
      if (m_full > 0) m_full--; else if (ff) m_full = 4;
      if (m_part > 0) m_part--; else if (fp) m_part = 4;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (full_rst) full_hi++;
    if (part_rst) part_hi++;
    if (chk_en) begin
      chk("R2", "full_rst_o", full_rst, (m_full > 0) ? 1 : 0);
      chk("R3", "part_rst_o", part_rst, (m_part > 0) ? 1 : 0);
      chk("R7", "trace_rst_o", trace_rst, m_trc);
      chk("R9", "irq_o", irq, (m_ist & m_ien));
      chk(rd_tag(int'(addr)), "bus_rdata", rdata, m_read(int'(addr)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(); addr = 10'(a); we = 1'b1; wdata = d;
    step(); we = 1'b0; wdata = '0; addr = '0;
  endtask

  task automatic rd(input string tag, input int a, input longint exp);
    addr = 10'(a); #1;
    chk(tag, $sformatf("read 0x%0h", a), rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();
    chk_en = 1;

    // R1: reset values
    rd("R1", 'h00C, 0);
    rd("R1", 'h000, 0);
    chk("R1", "outputs", {full_rst, part_rst, trace_rst, irq}, 0);

    // R8: gated brown-out and watchdog
    step(); req_bod = 1; req_wdt = 1; step(); req_bod = 0; req_wdt = 0;
    rd("R8", 'h00C, 'h00);
    wr('h000, 32'h1);
    step(); req_bod = 1; step(); req_bod = 0;
    rd("R8", 'h00C, 'h04);
    wr('h000, 32'h4);
    step(); req_wdt = 1; req_bod = 1; step(); req_wdt = 0; req_bod = 0;
    rd("R8", 'h00C, 'h44);
    rd("R8", 'h000, 'h4);

    // R6: clear write of 0 ignored, clear write of 1 empties log
    step(); req_ext = 1; step(); req_ext = 0;
    rd("R4", 'h00C, 'h45);
    wr('h010, 32'h0);
    rd("R6", 'h00C, 'h45);
    wr('h010, 32'h1);
    rd("R6", 'h00C, 'h00);

    // R2: wrong key ignored, correct key pulses 4 cycles
    full_hi = 0;
    wr('h008, 32'hD5);
    repeat (6) step();
    chk("R2", "full pulse wrong key", full_hi, 0);
    rd("R2", 'h00C, 'h00);
    wr('h008, 32'hD4);
    repeat (6) step();
    chk("R2", "full pulse cycles", full_hi, 4);
    rd("R2", 'h00C, 'h08);

    // R3: partial key, wrong key on partial offset
    part_hi = 0;
    wr('h004, 32'hD4);
    repeat (6) step();
    chk("R3", "part pulse wrong key", part_hi, 0);
    wr('h004, 32'h1B);
    repeat (6) step();
    chk("R3", "part pulse cycles", part_hi, 4);
    rd("R3", 'h00C, 'h18);

    // R10: second key during pulse is merged
    part_hi = 0;
    wr('h004, 32'h1B);
    wr('h004, 32'h1B);
    repeat (6) step();
    chk("R10", "merged part pulse cycles", part_hi, 4);

    // R4: accumulate debugger and system request
    step(); req_dbg = 1; step(); req_dbg = 0;
    step(); req_sys = 1; step(); req_sys = 0;
    rd("R4", 'h00C, 'h38);

    // R11: keys, clear and unmapped offsets read zero
    rd("R11", 'h004, 0);
    rd("R11", 'h008, 0);
    rd("R11", 'h010, 0);
    rd("R11", 'h208, 0);
    rd("R11", 'h20C, 0);
    rd("R11", 'h100, 0);
    addr = '0;

    // R5: power-on wipes other flags, wins over clear
    step(); req_por = 1; step(); req_por = 0;
    rd("R5", 'h00C, 'h02);
    step(); req_ext = 1; step(); req_ext = 0;
    step(); addr = 10'h010; we = 1; wdata = 32'h1; req_por = 1;
    step(); we = 0; wdata = '0; addr = '0; req_por = 0;
    rd("R5", 'h00C, 'h02);

    // R6: clear with simultaneous event keeps the event
    step(); addr = 10'h010; we = 1; wdata = 32'h1; req_ext = 1;
    step(); we = 0; wdata = '0; addr = '0; req_ext = 0;
    rd("R6", 'h00C, 'h01);

    // R7: static trace reset
    wr('h014, 32'h1);
    chk("R7", "trace set", trace_rst, 1);
    repeat (3) step();
    chk("R7", "trace held", trace_rst, 1);
    wr('h014, 32'h0);
    chk("R7", "trace released", trace_rst, 0);

    // R9: interrupt registers
    wr('h200, 32'h1);
    wr('h20C, 32'h1);
    chk("R9", "irq after set", irq, 1);
    wr('h208, 32'h0);
    chk("R9", "irq after clear 0", irq, 1);
    wr('h208, 32'h1);
    chk("R9", "irq after clear 1", irq, 0);
    step(); bod_hi = 1;
    step();
    chk("R9", "irq from level", irq, 1);
    addr = 10'h208; we = 1; wdata = 32'h1;
    step(); we = 0; wdata = '0; addr = '0;
    chk("R9", "set wins over clear", irq, 1);
    bod_hi = 0;
    wr('h208, 32'h1);
    chk("R9", "irq cleared", irq, 0);
    wr('h20C, 32'h1);
    wr('h200, 32'h0);
    chk("R9", "irq masked", irq, 0);
    rd("R9", 'h204, 1);
    addr = '0;

    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule